// File: doc/BRIEF.md
# Hardware monitor indexed register file

This block is the host-visible register file of a system hardware monitor. The host reaches it through two locations: an index location that holds a 7-bit register number, and a data location that reads or writes the register that the index selects. Measured voltages, a main temperature and fan counts arrive on input ports. They are captured into read-only registers every clock. Two auxiliary temperature sensors each own a small set of registers, and a bank number selects which set is visible.

Several registers behave specially. For a fixed group of registers in bank 0, the index steps forward after each data access, so software can stream through them without rewriting the index. The upper quarter of the address space is a second view of the measurement and limit window. Some registers ignore writes. One control register holds the bank number and also picks which byte of the 16-bit vendor identifier a single address returns. A soft-initialization bit restores every default except the bus address. Analog conversion and the serial bus front end are outside this block.

Top module: `hwmon_regfile`

## Requirements
- R1: A write to the index location (`acc_sel`=0) stores only bits 6:0 of the written byte. A read of the index location returns the stored index with bit 7 as 0.
- R2: With the active bank equal to 0, a data access (read or write) to register 0x41, 0x43, 0x45 or 0x56, or to any register from 0x60 to 0x7E, adds one to the index after the access. Every other data access leaves the index unchanged, and so does any data access while the bank is not 0.
- R3: Data addresses 0x60 to 0x7F reach the same storage as 0x20 to 0x3F (address bits 5:0 kept, bit 6 cleared), for reads and for writes.
- R4: Data writes to 0x20–0x2A, 0x41, 0x42, 0x4F and 0x58 have no effect, and neither do writes to their aliases 0x60–0x6A.
- R5: A data write to 0x40 with bit 7 set restores every register and both temperature sets to their defaults, except register 0x48, which keeps its value. Register 0x40 then reads 0x08.
- R6: After reset the index is 0 and the registers hold 0x40=0x08, 0x46=0x40, 0x47=0x50, 0x48=0x2D, 0x49=0x02, 0x4B=0x44, 0x4C=0x01, 0x4D=0x15, 0x4E=0x80, 0x57=0x80 and 0x58=0x10. Every other stored register holds 0x00.
- R7: A data read of 0x4F returns 0x5C when bit 7 of register 0x4E is 1 and 0xA3 when that bit is 0.
- R8: Bits 2:0 of register 0x4E are the active bank. When the bank is not 0, data addresses 0x50–0x56 go to a temperature set: bank 1 uses set 0, and banks 2 to 7 use set 1. In a set, 0x50 and 0x51 return the high and low bytes of that sensor's 16-bit `temp_aux` input and ignore writes. 0x52–0x56 are writable and default to 0x00, except 0x53=0x4B and 0x55=0x50. In bank 0, and for 0x57–0x5F in any bank, the main registers answer.
- R9: The fan register for fan i holds count >> n. Here n is bits 5:4 of 0x47 for fan 0, bits 7:6 of 0x47 for fan 1 and bits 7:6 of 0x4B for fan 2. A nonzero count that would shift to 0 reads as 1, and a zero count reads as 0.
- R10: Registers 0x20–0x26 return voltage byte i of `volt_bus` (bits 8i+7:8i), 0x27 returns `temp_main`, and 0x28–0x2A return fans 0–2 from `fan_bus` byte i after R9 scaling. These values are captured one clock after the inputs.
- R11: `rd_data` takes the read value on the clock edge that accepts a read strobe, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, one clock per access |
| acc_sel | input | 1 | 0 = index location, 1 = data location |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| volt_bus | input | 56 | Seven measured voltage bytes |
| temp_main | input | 8 | Main temperature byte |
| fan_bus | input | 24 | Three converted fan counts |
| temp_aux | input | 32 | Two 16-bit auxiliary temperatures, set 0 in bits 15:0 |

## Verification
The hardest state to reach from the ports is a soft initialization that lands on top of values already changed everywhere. The stimulus first moves the bus address, a limit, a control register and a temperature-set register away from their defaults. It then writes the initialization bit and reads each of them back, switching banks through the data port to reach the set. The index stepping is checked at its edges in the same way. The bench streams reads through the aliased window from 0x60 and then reads the index back. It also accesses 0x7F and 0x56 with the bank at 0 and at a nonzero value, to show where stepping stops.

// File: rtl/hwmon_pkg.sv
package hwmon_pkg;

    localparam int IDX_W      = 7;
    localparam int DATA_W     = 8;
    localparam int N_VOLT     = 7;
    localparam int N_FAN      = 3;
    localparam int MEAS_N     = N_VOLT + 1 + N_FAN;
    localparam int MAIN_DEPTH = 96;
    localparam int NUM_TSETS  = 2;
    localparam int TSET_SLOTS = 8;
    localparam logic [15:0] VENDOR_ID = 16'h5CA3;
    localparam logic [7:0]  CHIP_ID   = 8'h10;

    localparam logic [6:0] A_MEAS_BASE  = 7'h20;
    localparam logic [6:0] A_MEAS_LAST  = 7'h2A;
    localparam logic [6:0] A_CONFIG     = 7'h40;
    localparam logic [6:0] A_FAN_DIV_A  = 7'h47;
    localparam logic [6:0] A_BUS_ADDR   = 7'h48;
    localparam logic [6:0] A_FAN_DIV_B  = 7'h4B;
    localparam logic [6:0] A_BANK_CTL   = 7'h4E;
    localparam logic [6:0] A_VENDOR     = 7'h4F;
    localparam logic [6:0] A_TSET_BASE  = 7'h50;
    localparam logic [6:0] A_TSET_LAST  = 7'h56;
    localparam logic [6:0] A_CHIP_ID    = 7'h58;
    localparam logic [6:0] A_ALIAS_BASE = 7'h60;

    typedef enum logic {
        PORT_INDEX = 1'b0,
        PORT_DATA  = 1'b1
    } port_e;

    typedef struct packed {
        logic              valid;
        port_e             port;
        logic              write;
        logic [DATA_W-1:0] wdata;
    } host_acc_t;

    function automatic logic steps_index(input logic [IDX_W-1:0] a);
        return (a == 7'h41) || (a == 7'h43) || (a == 7'h45) || (a == 7'h56) ||
               ((a >= A_ALIAS_BASE) && (a <= 7'h7E));
    endfunction

    function automatic logic [IDX_W-1:0] fold_alias(input logic [IDX_W-1:0] a);
        return (a >= A_ALIAS_BASE) ? {1'b0, a[5:0]} : a;
    endfunction

    function automatic logic write_locked(input logic [IDX_W-1:0] a);
        return ((a >= A_MEAS_BASE) && (a <= A_MEAS_LAST)) ||
               (a == 7'h41) || (a == 7'h42) || (a == A_VENDOR) || (a == A_CHIP_ID);
    endfunction

    function automatic logic [DATA_W-1:0] main_default(input logic [IDX_W-1:0] a);
        case (a)
            A_CONFIG:    return 8'h08;
            7'h46:       return 8'h40;
            A_FAN_DIV_A: return 8'h50;
            A_BUS_ADDR:  return 8'h2D;
            7'h49:       return 8'h02;
            A_FAN_DIV_B: return 8'h44;
            7'h4C:       return 8'h01;
            7'h4D:       return 8'h15;
            A_BANK_CTL:  return 8'h80;
            7'h57:       return 8'h80;
            A_CHIP_ID:   return CHIP_ID;
            default:     return 8'h00;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] tset_default(input logic [2:0] off);
        case (off)
            3'd3:    return 8'h4B;
            3'd5:    return 8'h50;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] fan_scale(input logic [DATA_W-1:0] cnt,
                                                    input logic [1:0] n);
        logic [DATA_W-1:0] r;
        r = cnt >> n;
        if ((cnt != '0) && (r == '0)) r = 8'd1;
        return r;
    endfunction

endpackage

// File: rtl/hwmon_index_ctl.sv
module hwmon_index_ctl
    import hwmon_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             idx_wr,
    input  logic [IDX_W-1:0] idx_wdata,
    input  logic             data_acc,
    input  logic             bank_zero,
    output logic [IDX_W-1:0] idx_q
);

    logic step;
    assign step = data_acc && bank_zero && steps_index(idx_q);

    always_ff @(posedge clk) begin
        if (rst)         idx_q <= '0;
        else if (idx_wr) idx_q <= idx_wdata;
        else if (step)   idx_q <= idx_q + 7'd1;
    end

    // R2: listed registers in bank 0 advance the index
    a_r2_index_steps: assert property (@(posedge clk) disable iff (rst)
        (data_acc && bank_zero && steps_index(idx_q)) |=> (idx_q == $past(idx_q) + 7'd1));

    // R2: all other data accesses leave the index alone
    a_r2_index_holds: assert property (@(posedge clk) disable iff (rst)
        (data_acc && !idx_wr && !(bank_zero && steps_index(idx_q))) |=> $stable(idx_q));

endmodule

// File: rtl/hwmon_main_file.sv
module hwmon_main_file
    import hwmon_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  init,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [IDX_W-1:0]      rd_addr,
    output logic [DATA_W-1:0]     rd_val,
    output logic [2:0]            bank_num,
    output logic                  vid_hi,
    output logic [N_FAN-1:0][1:0] fan_div
);

    logic [DATA_W-1:0] mem [MAIN_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MAIN_DEPTH; i++) mem[i] <= main_default(IDX_W'(i));
        end else if (init) begin
            for (int i = 0; i < MAIN_DEPTH; i++)
                if (IDX_W'(i) != A_BUS_ADDR) mem[i] <= main_default(IDX_W'(i));
        end else if (wr_en && !write_locked(wr_addr)) begin
            mem[wr_addr] <= wdata;
        end
    end

    assign rd_val     = mem[rd_addr];
    assign bank_num   = mem[A_BANK_CTL][2:0];
    assign vid_hi     = mem[A_BANK_CTL][7];
    assign fan_div[0] = mem[A_FAN_DIV_A][5:4];
    assign fan_div[1] = mem[A_FAN_DIV_A][7:6];
    assign fan_div[2] = mem[A_FAN_DIV_B][7:6];

    logic [DATA_W-1:0] tgt_now;
    assign tgt_now = mem[wr_addr];

    // R4: locked registers keep their content across a write
    a_r4_locked_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !init && write_locked(wr_addr)) |=> (mem[$past(wr_addr)] == $past(tgt_now)));

    // R5: soft initialization keeps the bus address
    a_r5_bus_addr_kept: assert property (@(posedge clk) disable iff (rst)
        init |=> (mem[A_BUS_ADDR] == $past(mem[A_BUS_ADDR])));

    // R5: soft initialization restores control defaults
    a_r5_defaults_back: assert property (@(posedge clk) disable iff (rst)
        init |=> (mem[A_CONFIG] == 8'h08 && mem[A_BANK_CTL] == 8'h80));

endmodule

// File: rtl/hwmon_meas_capture.sv
module hwmon_meas_capture
    import hwmon_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N_VOLT*DATA_W-1:0]    volt_bus,
    input  logic [DATA_W-1:0]           temp_main,
    input  logic [N_FAN*DATA_W-1:0]     fan_bus,
    input  logic [N_FAN-1:0][1:0]       fan_div,
    output logic [MEAS_N-1:0][DATA_W-1:0] meas_q
);

    localparam int TEMP_SLOT = N_VOLT;
    localparam int FAN_SLOT  = N_VOLT + 1;

    for (genvar v = 0; v < N_VOLT; v++) begin : g_volt
        always_ff @(posedge clk) begin
            if (rst) meas_q[v] <= '0;
            else     meas_q[v] <= volt_bus[v*DATA_W +: DATA_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) meas_q[TEMP_SLOT] <= '0;
        else     meas_q[TEMP_SLOT] <= temp_main;
    end

    for (genvar f = 0; f < N_FAN; f++) begin : g_fan
        always_ff @(posedge clk) begin
            if (rst) meas_q[FAN_SLOT+f] <= '0;
            else     meas_q[FAN_SLOT+f] <= fan_scale(fan_bus[f*DATA_W +: DATA_W], fan_div[f]);
        end

        // R9: an absent fan reads zero, a present one never reads zero
        a_r9_fan_presence: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> ((meas_q[FAN_SLOT+f] == '0) == ($past(fan_bus[f*DATA_W +: DATA_W]) == '0)));
    end

endmodule

// File: rtl/hwmon_tset.sv
module hwmon_tset
    import hwmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              wr_en,
    input  logic [2:0]        wr_off,
    input  logic [DATA_W-1:0] wdata,
    input  logic [15:0]       temp_in,
    input  logic [2:0]        rd_off,
    output logic [DATA_W-1:0] rd_val
);

    logic [DATA_W-1:0] lim [TSET_SLOTS];
    logic [15:0]       temp_q;

    always_ff @(posedge clk) begin
        if (rst) temp_q <= '0;
        else     temp_q <= temp_in;
    end

    always_ff @(posedge clk) begin
        if (rst || init) begin
            for (int i = 0; i < TSET_SLOTS; i++) lim[i] <= tset_default(3'(i));
        end else if (wr_en && (wr_off >= 3'd2)) begin
            lim[wr_off] <= wdata;
        end
    end

    always_comb begin
        case (rd_off)
            3'd0:    rd_val = temp_q[15:8];
            3'd1:    rd_val = temp_q[7:0];
            default: rd_val = lim[rd_off];
        endcase
    end

    // R8: writable slots take the written byte
    a_r8_slot_written: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !init && wr_off >= 3'd2) |=> (lim[$past(wr_off)] == $past(wdata)));

endmodule

// File: rtl/hwmon_regfile.sv
module hwmon_regfile
    import hwmon_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        acc_valid,
    input  logic        acc_sel,
    input  logic        acc_write,
    input  logic [7:0]  acc_wdata,
    output logic [7:0]  rd_data,
    input  logic [55:0] volt_bus,
    input  logic [7:0]  temp_main,
    input  logic [23:0] fan_bus,
    input  logic [31:0] temp_aux
);

    localparam int TS_W = (NUM_TSETS > 1) ? $clog2(NUM_TSETS) : 1;

    host_acc_t acc;
    assign acc = '{valid: acc_valid, port: port_e'(acc_sel), write: acc_write, wdata: acc_wdata};

    logic idx_wr, idx_rd, data_acc, data_wr, data_rd;
    assign idx_wr   = acc.valid && (acc.port == PORT_INDEX) && acc.write;
    assign idx_rd   = acc.valid && (acc.port == PORT_INDEX) && !acc.write;
    assign data_acc = acc.valid && (acc.port == PORT_DATA);
    assign data_wr  = data_acc && acc.write;
    assign data_rd  = data_acc && !acc.write;

    logic [IDX_W-1:0]      idx_q, eff;
    logic [2:0]            bank_num;
    logic                  bank_zero, vid_hi, tset_hit, init_req, main_wr;
    logic [TS_W-1:0]       tsel;
    logic [N_FAN-1:0][1:0] fan_div;
    logic [DATA_W-1:0]     main_rd, rd_next;
    logic [MEAS_N-1:0][DATA_W-1:0] meas_q;
    logic [DATA_W-1:0]     tset_rd [NUM_TSETS];
    logic [3:0]            moff;

    assign eff       = fold_alias(idx_q);
    assign bank_zero = (bank_num == 3'd0);
    assign tset_hit  = !bank_zero && (idx_q >= A_TSET_BASE) && (idx_q <= A_TSET_LAST);
    assign tsel      = (int'(bank_num) > NUM_TSETS) ? TS_W'(NUM_TSETS - 1)
                                                    : TS_W'(bank_num - 3'd1);
    assign init_req  = data_wr && !tset_hit && (eff == A_CONFIG) && acc.wdata[7];
    assign main_wr   = data_wr && !tset_hit && !init_req;
    assign moff      = 4'(eff - A_MEAS_BASE);

    hwmon_index_ctl u_index (
        .clk       (clk),
        .rst       (rst),
        .idx_wr    (idx_wr),
        .idx_wdata (acc.wdata[IDX_W-1:0]),
        .data_acc  (data_acc),
        .bank_zero (bank_zero),
        .idx_q     (idx_q)
    );

    hwmon_main_file u_main (
        .clk      (clk),
        .rst      (rst),
        .init     (init_req),
        .wr_en    (main_wr),
        .wr_addr  (eff),
        .wdata    (acc.wdata),
        .rd_addr  (eff),
        .rd_val   (main_rd),
        .bank_num (bank_num),
        .vid_hi   (vid_hi),
        .fan_div  (fan_div)
    );

    hwmon_meas_capture u_meas (
        .clk       (clk),
        .rst       (rst),
        .volt_bus  (volt_bus),
        .temp_main (temp_main),
        .fan_bus   (fan_bus),
        .fan_div   (fan_div),
        .meas_q    (meas_q)
    );

    for (genvar g = 0; g < NUM_TSETS; g++) begin : g_tset
        hwmon_tset u_tset (
            .clk     (clk),
            .rst     (rst),
            .init    (init_req),
            .wr_en   (data_wr && tset_hit && (tsel == TS_W'(g))),
            .wr_off  (idx_q[2:0]),
            .wdata   (acc.wdata),
            .temp_in (temp_aux[g*16 +: 16]),
            .rd_off  (idx_q[2:0]),
            .rd_val  (tset_rd[g])
        );
    end

    always_comb begin
        if (acc.port == PORT_INDEX)
            rd_next = {1'b0, idx_q};
        else if (tset_hit)
            rd_next = tset_rd[tsel];
        else if ((eff >= A_MEAS_BASE) && (eff <= A_MEAS_LAST))
            rd_next = meas_q[moff];
        else if (eff == A_VENDOR)
            rd_next = vid_hi ? VENDOR_ID[15:8] : VENDOR_ID[7:0];
        else
            rd_next = main_rd;
    end

    always_ff @(posedge clk) begin
        if (rst)                  rd_data <= '0;
        else if (idx_rd || data_rd) rd_data <= rd_next;
    end

    // R1: index reads show the index with bit 7 clear
    a_r1_index_read: assert property (@(posedge clk) disable iff (rst)
        idx_rd |=> (rd_data == {1'b0, $past(idx_q)}));

    // R11: read data holds between reads
    a_r11_rd_hold: assert property (@(posedge clk) disable iff (rst)
        !(idx_rd || data_rd) |=> $stable(rd_data));

    // R7: the identifier address yields one of the two identifier bytes
    a_r7_vendor_byte: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !tset_hit && eff == A_VENDOR) |=>
        (rd_data == VENDOR_ID[15:8] || rd_data == VENDOR_ID[7:0]));

endmodule

// File: tb/hwmon_regfile_test.sv
module hwmon_regfile_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_sel = 1'b0;
    logic        acc_write = 1'b0;
    logic [7:0]  acc_wdata = '0;
    logic [7:0]  rd_data;
    logic [55:0] volt_bus = '0;
    logic [7:0]  temp_main = '0;
    logic [23:0] fan_bus = '0;
    logic [31:0] temp_aux = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hwmon_regfile uut (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_sel   (acc_sel),
        .acc_write (acc_write),
        .acc_wdata (acc_wdata),
        .rd_data   (rd_data),
        .volt_bus  (volt_bus),
        .temp_main (temp_main),
        .fan_bus   (fan_bus),
        .temp_aux  (temp_aux)
    );

    // Monitor: every accepted read pops one expected item
    always @(posedge clk) begin
        if (!rst && acc_valid && !acc_write) begin
            #1;
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R11 unexpected read: actual=%02h expected=none", rd_data);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    failures++;
                    $display("FAIL %s: actual=%02h expected=%02h", t, rd_data, e);
                end
            end
        end
    end

    task automatic access(input logic sel, input logic wr, input logic [7:0] wd);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_sel   = sel;
        acc_write = wr;
        acc_wdata = wd;
        @(negedge clk);
        acc_valid = 1'b0;
        acc_write = 1'b0;
    endtask

    task automatic set_idx(input logic [7:0] a);
        access(1'b0, 1'b1, a);
    endtask

    task automatic wr_data(input logic [7:0] v);
        access(1'b1, 1'b1, v);
    endtask

    task automatic rd_data_exp(input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        access(1'b1, 1'b0, 8'h00);
    endtask

    task automatic rd_idx_exp(input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        access(1'b0, 1'b0, 8'h00);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] v);
        set_idx(a);
        wr_data(v);
    endtask

    task automatic rd_reg(input logic [7:0] a, input logic [7:0] e, input string t);
        set_idx(a);
        rd_data_exp(e, t);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [7:0] fan_exp(input logic [7:0] c, input int n);
        logic [7:0] r;
        r = c >> n;
        if (c != 0 && r == 0) r = 8'd1;
        return r;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 7; i++) volt_bus[8*i +: 8] = 8'h30 + 8'(i * 8'h11);
        temp_main = 8'h2E;
        fan_bus   = {8'h00, 8'h01, 8'h80};
        temp_aux  = {16'h2A00, 16'h1980};
        do_reset();

        // R6 reset state
        rd_idx_exp(8'h00, "R6 index after reset");
        rd_reg(8'h40, 8'h08, "R6 0x40");
        rd_reg(8'h46, 8'h40, "R6 0x46");
        rd_reg(8'h47, 8'h50, "R6 0x47");
        rd_reg(8'h48, 8'h2D, "R6 0x48");
        rd_reg(8'h49, 8'h02, "R6 0x49");
        rd_reg(8'h4B, 8'h44, "R6 0x4B");
        rd_reg(8'h4C, 8'h01, "R6 0x4C");
        rd_reg(8'h4D, 8'h15, "R6 0x4D");
        rd_reg(8'h4E, 8'h80, "R6 0x4E");
        rd_reg(8'h57, 8'h80, "R6 0x57");
        rd_reg(8'h2C, 8'h00, "R6 limit zero");

        // R1 index masking
        set_idx(8'hC5);
        rd_idx_exp(8'h45, "R1 index keeps 7 bits");

        // R7 vendor byte selection
        rd_reg(8'h4F, 8'h5C, "R7 high byte");
        wr_reg(8'h4E, 8'h00);
        rd_reg(8'h4F, 8'hA3, "R7 low byte");
        wr_reg(8'h4F, 8'h11);
        rd_reg(8'h4F, 8'hA3, "R7 write ignored");
        wr_reg(8'h4E, 8'h80);

        // R3 alias window
        wr_reg(8'h2B, 8'h77);
        rd_reg(8'h6B, 8'h77, "R3 read through alias");
        rd_idx_exp(8'h6C, "R2 step after alias read");
        wr_reg(8'h7F, 8'h99);
        rd_idx_exp(8'h7F, "R2 no step at 0x7F");
        rd_reg(8'h3F, 8'h99, "R3 write through alias");

        // R2 stepping set
        rd_reg(8'h43, 8'h00, "R2 read 0x43");
        rd_idx_exp(8'h44, "R2 step at 0x43");
        rd_reg(8'h42, 8'h00, "R2 read 0x42");
        rd_idx_exp(8'h42, "R2 no step at 0x42");
        wr_reg(8'h45, 8'h3A);
        rd_idx_exp(8'h46, "R2 step on write 0x45");
        rd_reg(8'h56, 8'h00, "R2 read 0x56 bank 0");
        rd_idx_exp(8'h57, "R2 step at 0x56 bank 0");

        // R4 locked registers
        wr_reg(8'h41, 8'hFF);
        rd_reg(8'h41, 8'h00, "R4 0x41 locked");
        wr_reg(8'h58, 8'h00);
        rd_reg(8'h58, 8'h10, "R4 0x58 locked");
        wr_reg(8'h65, 8'hEE);
        rd_reg(8'h25, 8'h30 + 8'(5 * 8'h11), "R4 alias 0x65 locked");
        wr_reg(8'h2A, 8'hEE);
        rd_reg(8'h2A, 8'h00, "R4 0x2A locked");

        // R10 measurements streamed through the alias window
        set_idx(8'h60);
        for (int i = 0; i < 7; i++) rd_data_exp(8'h30 + 8'(i * 8'h11), "R10 voltage");
        rd_data_exp(8'h2E, "R10 temperature");
        rd_data_exp(fan_exp(8'h80, 1), "R9 fan0 default divisor");
        rd_data_exp(fan_exp(8'h01, 1), "R9 fan1 clamps to 1");
        rd_data_exp(8'h00, "R9 fan2 absent");
        rd_idx_exp(8'h6B, "R2 index after stream");

        // R9 divisor fields
        fan_bus = {8'h05, 8'h01, 8'hF0};
        wr_reg(8'h47, 8'h30);
        wr_reg(8'h4B, 8'hC0);
        repeat (2) @(negedge clk);
        rd_reg(8'h28, fan_exp(8'hF0, 3), "R9 fan0 n=3");
        rd_reg(8'h29, fan_exp(8'h01, 0), "R9 fan1 n=0");
        rd_reg(8'h2A, fan_exp(8'h05, 3), "R9 fan2 n=3 clamp");

        // R8 temperature sets
        wr_reg(8'h4E, 8'h81);
        rd_reg(8'h50, 8'h19, "R8 set0 high");
        rd_reg(8'h51, 8'h80, "R8 set0 low");
        wr_reg(8'h50, 8'h00);
        rd_reg(8'h50, 8'h19, "R8 set0 high locked");
        rd_reg(8'h53, 8'h4B, "R8 set0 0x53 default");
        rd_reg(8'h55, 8'h50, "R8 set0 0x55 default");
        wr_reg(8'h52, 8'hAA);
        rd_reg(8'h52, 8'hAA, "R8 set0 0x52 written");
        rd_reg(8'h56, 8'h00, "R8 set0 0x56");
        rd_idx_exp(8'h56, "R2 no step in bank 1");
        rd_reg(8'h57, 8'h80, "R8 0x57 from main in bank 1");
        wr_reg(8'h4E, 8'h85);
        rd_reg(8'h50, 8'h2A, "R8 set1 high via bank 5");
        rd_reg(8'h52, 8'h00, "R8 set1 separate");
        wr_reg(8'h54, 8'h3C);
        rd_reg(8'h54, 8'h3C, "R8 set1 0x54 written");
        wr_reg(8'h4E, 8'h81);
        rd_reg(8'h52, 8'hAA, "R8 set0 kept");
        wr_reg(8'h4E, 8'h80);
        rd_reg(8'h53, 8'h00, "R8 bank 0 reaches main 0x53");

        // R5 soft initialization
        wr_reg(8'h48, 8'h2A);
        wr_reg(8'h2B, 8'h55);
        wr_reg(8'h46, 8'h12);
        wr_reg(8'h40, 8'h80);
        rd_reg(8'h48, 8'h2A, "R5 bus address kept");
        rd_reg(8'h46, 8'h40, "R5 0x46 restored");
        rd_reg(8'h2B, 8'h00, "R5 limit cleared");
        rd_reg(8'h40, 8'h08, "R5 config reads 0x08");
        rd_reg(8'h47, 8'h50, "R5 divisor restored");
        rd_reg(8'h4E, 8'h80, "R5 bank control restored");
        wr_reg(8'h4E, 8'h81);
        rd_reg(8'h52, 8'h00, "R5 set0 restored");
        wr_reg(8'h4E, 8'h80);

        // R6 hard reset restores the bus address
        do_reset();
        rd_reg(8'h48, 8'h2D, "R6 bus address after reset");

        // R11 hold: idle cycles and an index write do not disturb rd_data
        set_idx(8'h10);
        repeat (3) @(negedge clk);
        checks++;
        if (rd_data !== 8'h2D) begin
            failures++;
            $display("FAIL R11 hold: actual=%02h expected=2d", rd_data);
        end

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R11 pending reads: actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule